// File: doc/BRIEF.md
# Byte-Masked Line Merge Unit

This block holds one cache line of data together with a per-byte record of which bytes were written locally. Stores write only their enabled bytes and add those bytes to the record. A fill from the next level replaces the rest of the line but never the locally written bytes. The control around the block uses the combinational `covered_o` flag to decide whether a load can be answered from the locally written bytes. That is the case only when the load's byte mask equals the accumulated record. Otherwise the surrounding logic issues a read of the whole block.

Allocation and invalidation both clear the record. The full line and the record are always visible at the outputs, so a write-through or eviction can send the line together with a copy of its written-byte mask. Tag and state handling sit outside this block. Every operation takes effect on a single rising clock edge.

Top module: `line_merge_unit`

## Requirements
- R1: After reset, `wmask_o` is all zero and every byte of `line_data_o` is zero.
- R2: A store (`store_i`=1) replaces byte i of the line (bits 8i+7..8i) with byte i of `store_data_i` only where `store_be_i[i]`=1. All other bytes keep their value.
- R3: A store ORs `store_be_i` into the written-byte mask. Without allocate or invalidate, the mask never loses a set bit.
- R4: A fill (`fill_i`=1) loads byte i from `fill_data_i` where mask bit i is 0. Where mask bit i is 1, the byte keeps its locally written value.
- R5: When a store and a fill arrive in the same cycle, the fill is applied first and the store after it, so the stored bytes win.
- R6: Allocate (`alloc_i`=1) clears the mask. A store or fill in the same cycle is applied as if the mask were already clear, so such a fill overwrites every byte that the store does not write.
- R7: Invalidate (`inval_i`=1) clears the mask, leaves the line data unchanged and ignores any store or fill in the same cycle. It takes priority over allocate.
- R8: `covered_o` is 1 exactly when `load_be_i` equals the current mask. It follows `load_be_i` in the same cycle, so an all-zero load mask against an all-zero write mask gives 1.
- R9: With no operation asserted, `line_data_o` and `wmask_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_i | input | 1 | Allocate: clear written-byte mask |
| inval_i | input | 1 | Invalidate: clear mask, ignore store/fill |
| store_i | input | 1 | Store request |
| store_be_i | input | LINE_BYTES | Store byte enables |
| store_data_i | input | LINE_BYTES*8 | Store data, line aligned |
| fill_i | input | 1 | Fill from next level |
| fill_data_i | input | LINE_BYTES*8 | Fill line data |
| load_be_i | input | LINE_BYTES | Load byte mask for the coverage check |
| line_data_o | output | LINE_BYTES*8 | Current line data |
| wmask_o | output | LINE_BYTES | Accumulated written-byte mask |
| covered_o | output | 1 | Load mask equals written mask |

## Verification
The bench targets fills that land on written bytes. A design that ignores the mask there would replace local data with the incoming line. It drives a store and a fill in the same cycle, where a reversed order would leave fill bytes in the stored positions. It combines allocate with a fill, where a stale mask would keep old bytes, and invalidate with a store, where a leaky priority would alter data or leave mask bits set. The coverage flag is checked at exact equality, with one extra mask bit, and for the all-zero case, where a subset or any-bit test would give the wrong answer.

// File: rtl/lmu_pkg.sv
package lmu_pkg;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/lmu_byte_lane.sv
module lmu_byte_lane
  import lmu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic              inval_i,
  input  logic              st_en_i,
  input  logic [BYTE_W-1:0] st_byte_i,
  input  logic              fl_en_i,
  input  logic [BYTE_W-1:0] fl_byte_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              wbit_o
);
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              wbit_q, wbit_d, base_w;

  always_comb begin
    base_w = alloc_i ? 1'b0 : wbit_q;
    byte_d = byte_q;
    wbit_d = base_w | st_en_i;
    if (inval_i) begin
      wbit_d = 1'b0;
    end else begin
      // fill first, store on top
      if (fl_en_i && !base_w) byte_d = fl_byte_i;
      if (st_en_i)            byte_d = st_byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= '0;
      wbit_q <= 1'b0;
    end else begin
      byte_q <= byte_d;
      wbit_q <= wbit_d;
    end
  end

  assign byte_o = byte_q;
  assign wbit_o = wbit_q;

  // R5
  lane_store_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_en_i && !inval_i) |=> (byte_o == $past(st_byte_i)));
  // R4
  lane_fill_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_en_i && !st_en_i && wbit_o && !alloc_i && !inval_i) |=> $stable(byte_o));
  // R7
  lane_inval_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> ($stable(byte_o) && !wbit_o));
endmodule

// File: rtl/lmu_cover_check.sv
module lmu_cover_check #(
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic [LINE_BYTES-1:0] load_be_i,
  input  logic [LINE_BYTES-1:0] wmask_i,
  output logic                  covered_o
);
  logic [LINE_BYTES-1:0] diff;
  assign diff      = load_be_i ^ wmask_i;
  assign covered_o = (diff == '0);
endmodule

// File: rtl/line_merge_unit.sv
module line_merge_unit
  import lmu_pkg::*;
#(
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         alloc_i,
  input  logic                         inval_i,
  input  logic                         store_i,
  input  logic [LINE_BYTES-1:0]        store_be_i,
  input  logic [LINE_BYTES*BYTE_W-1:0] store_data_i,
  input  logic                         fill_i,
  input  logic [LINE_BYTES*BYTE_W-1:0] fill_data_i,
  input  logic [LINE_BYTES-1:0]        load_be_i,
  output logic [LINE_BYTES*BYTE_W-1:0] line_data_o,
  output logic [LINE_BYTES-1:0]        wmask_o,
  output logic                         covered_o
);
  localparam int unsigned LINE_W = LINE_BYTES * BYTE_W;

  logic [LINE_W-1:0]     data_w;
  logic [LINE_BYTES-1:0] mask_w;

  for (genvar g = 0; g < LINE_BYTES; g++) begin : g_lane
    lmu_byte_lane u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .alloc_i   (alloc_i),
      .inval_i   (inval_i),
      .st_en_i   (store_i & store_be_i[g]),
      .st_byte_i (store_data_i[g*BYTE_W +: BYTE_W]),
      .fl_en_i   (fill_i),
      .fl_byte_i (fill_data_i[g*BYTE_W +: BYTE_W]),
      .byte_o    (data_w[g*BYTE_W +: BYTE_W]),
      .wbit_o    (mask_w[g])
    );
  end

  lmu_cover_check #(.LINE_BYTES(LINE_BYTES)) u_cover (
    .load_be_i (load_be_i),
    .wmask_i   (mask_w),
    .covered_o (covered_o)
  );

  assign line_data_o = data_w;
  assign wmask_o     = mask_w;

  // R3
  mask_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alloc_i && !inval_i) |=> ((wmask_o & $past(wmask_o)) == $past(wmask_o)));
  // R3
  mask_store_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && !inval_i) |=> ((wmask_o & $past(store_be_i)) == $past(store_be_i)));
  // R7
  inval_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> (wmask_o == '0));
  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alloc_i && !inval_i && !store_i && !fill_i) |=> ($stable(line_data_o) && $stable(wmask_o)));
endmodule

// File: tb/tb_line_merge_unit.sv
module tb_line_merge_unit;
  localparam int unsigned NB = 64;
  localparam int unsigned LW = NB * 8;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic          alloc;
    logic          inval;
    logic          st;
    logic          fl;
    logic [NB-1:0] be;
    logic [7:0]    sseed;
    logic [7:0]    fseed;
    logic [NB-1:0] lbe;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 1'b0, 64'h0000_0000_0000_00FF, 8'h10, 8'h00, 64'h0000_0000_0000_00FF},
    '{1'b0, 1'b0, 1'b1, 1'b0, 64'hFF00_0000_0000_0000, 8'h20, 8'h00, 64'h0000_0000_0000_00FF},
    '{1'b0, 1'b0, 1'b0, 1'b1, 64'h0,                   8'h00, 8'h33, 64'hFF00_0000_0000_00FF},
    '{1'b0, 1'b0, 1'b1, 1'b1, 64'h0000_0000_0000_0F00, 8'h44, 8'h55, 64'hFF00_0000_0000_0FFF},
    '{1'b0, 1'b0, 1'b0, 1'b1, 64'h0,                   8'h00, 8'h5A, 64'hFF00_0000_0000_1FFF},
    '{1'b1, 1'b0, 1'b1, 1'b0, 64'h0000_0000_0000_00F0, 8'h66, 8'h00, 64'h0000_0000_0000_00F0},
    '{1'b1, 1'b0, 1'b1, 1'b1, 64'h0000_0000_0000_0003, 8'h88, 8'h77, 64'h0000_0000_0000_0001},
    '{1'b0, 1'b1, 1'b1, 1'b1, 64'hFFFF_0000_0000_0000, 8'hC1, 8'hC2, 64'h0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 64'h0,                   8'h00, 8'h99, 64'h0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hAA, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF},
    '{1'b0, 1'b0, 1'b0, 1'b0, 64'h0,                   8'h00, 8'h00, 64'h0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 64'h0,                   8'h00, 8'h00, 64'h0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc = 1'b0, inval = 1'b0, st = 1'b0, fl = 1'b0;
  logic [NB-1:0] be = '0, lbe = '0;
  logic [LW-1:0] sdata = '0, fdata = '0;
  logic [LW-1:0] line_data;
  logic [NB-1:0] wmask;
  logic          covered;

  logic [LW-1:0] m_data = '0;
  logic [NB-1:0] m_mask = '0;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_merge_unit #(.LINE_BYTES(NB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .alloc_i(alloc), .inval_i(inval),
    .store_i(st), .store_be_i(be), .store_data_i(sdata),
    .fill_i(fl), .fill_data_i(fdata), .load_be_i(lbe),
    .line_data_o(line_data), .wmask_o(wmask), .covered_o(covered)
  );

  function automatic logic [LW-1:0] pat(input logic [7:0] seed);
    logic [LW-1:0] r;
    for (int i = 0; i < NB; i++) r[i*8 +: 8] = seed ^ 8'(i * 3);
    return r;
  endfunction

  task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic [NB-1:0] base;
    if (inval) begin
      m_mask = '0;
    end else begin
      base = alloc ? '0 : m_mask;
      for (int i = 0; i < NB; i++) begin
        if (fl && !base[i]) m_data[i*8 +: 8] = fdata[i*8 +: 8];
        if (st && be[i])    m_data[i*8 +: 8] = sdata[i*8 +: 8];
      end
      m_mask = base | (st ? be : '0);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    alloc = v.alloc; inval = v.inval; st = v.st; fl = v.fl;
    be = v.be; sdata = pat(v.sseed); fdata = pat(v.fseed); lbe = v.lbe;
    model_step();
    @(negedge clk);
    alloc = 1'b0; inval = 1'b0; st = 1'b0; fl = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 data", line_data, '0);
    chk("R1 mask", LW'(wmask), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6 R7 R8 walked by the table
    for (int k = 0; k < NV; k++) begin
      apply(VECS[k]);
      chk("R2 R4 R5 R6 R7 data", line_data, m_data);
      chk("R3 R6 R7 mask", LW'(wmask), LW'(m_mask));
      chk("R8 covered", LW'(covered), LW'(VECS[k].lbe == m_mask));
    end

    // R8 one extra bit breaks coverage, exact match restores it
    apply('{1'b0, 1'b0, 1'b1, 1'b0, 64'h0000_0000_0000_0005, 8'hE1, 8'h00, 64'h0});
    lbe = 64'h0000_0000_0000_0007;
    #1 chk("R8 superset", LW'(covered), LW'(0));
    lbe = 64'h0000_0000_0000_0005;
    #1 chk("R8 exact", LW'(covered), LW'(1));

    // R9 idle holds line and mask
    repeat (3) @(negedge clk);
    chk("R9 data hold", line_data, m_data);
    chk("R9 mask hold", LW'(wmask), LW'(m_mask));

    // R4 fill keeps written bytes 0 and 2
    apply('{1'b0, 1'b0, 1'b0, 1'b1, 64'h0, 8'h00, 8'hF0, 64'h0});
    chk("R4 written byte0", LW'(line_data[7:0]), LW'(8'hE1 ^ 8'd0));
    chk("R4 written byte2", LW'(line_data[23:16]), LW'(8'hE1 ^ 8'd6));
    chk("R4 filled byte1", LW'(line_data[15:8]), LW'(8'hF0 ^ 8'd3));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule